// File: doc/BRIEF.md
# Depth-Cascadable FIFO Slice

A first-in first-out slice holds a small memory with its own write and read pointers, occupancy counter and empty, full and half-full flags. Identical slices are chained into a ring to build a deeper queue. All slices see the same write and read strobes, but only the slice that currently owns the write token stores a word, and only the slice that owns the read token presents and pops one. When a slice uses the last location of its memory, it hands the token to its neighbour through a two-bit expansion link. Bit 0 of the link carries the write handoff and bit 1 carries the read handoff, so both can travel in the same clock without being confused.

The top level chains `NSLICE` slices, three by default. It ties the first-load select of slice 0 low and the select of every other slice high, closes the ring, and forms the composite flags. The composite full flag is the OR of the per-slice full flags, and the composite empty flag is the OR of the per-slice empty flags. Strobes are sampled on one system clock. Read data is shown ahead: `dout` already holds the oldest word while the queue is not empty, and a read strobe removes that word.

Top module: `cascade_fifo`

## Requirements
- R1: While `rst_n` is low, and after it is released, the queue is empty. `empty`=1, `full`=0, and every `half_full` bit is 0.
- R2: After reset, the slice whose first-load select is low (slice 0) holds both tokens. Exactly one slice holds the write token at any time, and exactly one holds the read token.
- R3: Words leave in the order they were written, across slice boundaries. While `empty`=0, `dout` shows the oldest stored word.
- R4: A slice that accepts a write into its last memory location passes the write token to the next slice in the ring, so word k is stored in slice (k / DEPTH) mod NSLICE. A slice without the write token ignores the write strobe.
- R5: A slice that accepts a read from its last memory location passes the read token in the same way, so reads drain the slices in the same order they were filled.
- R6: `full` is 1 exactly when NSLICE*DEPTH words are stored. `empty` is 1 exactly when no word is stored.
- R7: A write strobe while `full`=1 and a read strobe while `empty`=1 are ignored. The stored contents and the pointers do not change.
- R8: Bit i of `half_full` is 1 exactly when slice i holds more than DEPTH/2 words.
- R9: A write and a read in the same cycle, when the queue is neither full nor empty, both take effect. When the queue is full, only the read takes effect. When it is empty, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears pointers and reloads token ownership |
| wr_en | input | 1 | Write strobe |
| din | input | WIDTH | Write data |
| rd_en | input | 1 | Read strobe |
| dout | output | WIDTH | Oldest stored word (show-ahead) |
| full | output | 1 | Composite full flag |
| empty | output | 1 | Composite empty flag |
| half_full | output | NSLICE | Per-slice half-full flags |

## Verification
The bench goes after the token handoffs at every slice boundary and at the wrap from the last slice back to the first. A design that passed a token one location early or late would return words out of order, or light the wrong `half_full` bit. It strobes writes into a full queue and reads from an empty one. A design that moved a pointer anyway would later return a duplicated or skipped word, or report the wrong flag. It also drives simultaneous read and write at the full and empty boundaries and across long mixed runs. A design that resolved the two strobes in the wrong order would lose a word or underflow.

// File: rtl/cascade_fifo_slice.sv
module cascade_fifo_slice #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             first_load_n,
  input  logic             wr_go,
  input  logic             rd_go,
  input  logic [WIDTH-1:0] din,
  input  logic [1:0]       xi,
  output logic [1:0]       xo,
  output logic [WIDTH-1:0] q,
  output logic             empty_f,
  output logic             full_f,
  output logic             half_f,
  output logic             wtok,
  output logic             rtok,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  wire wr_here = wr_go & wtok;
  wire rd_here = rd_go & rtok;
  wire wlast   = (wptr == AW'(DEPTH-1));
  wire rlast   = (rptr == AW'(DEPTH-1));

  assign xo[0]   = wr_here & wlast;
  assign xo[1]   = rd_here & rlast;
  assign q       = rtok ? mem[rptr] : '0;
  assign empty_f = rtok & (count == '0);
  assign full_f  = wtok & (count == CW'(DEPTH));
  assign half_f  = (count > CW'(DEPTH/2));

  always_ff @(posedge clk) begin
    if (wr_here) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      wtok  <= ~first_load_n;
      rtok  <= ~first_load_n;
    end else begin
      if (wr_here) wptr <= wlast ? '0 : wptr + AW'(1);
      if (rd_here) rptr <= rlast ? '0 : rptr + AW'(1);
      count <= count + CW'(wr_here) - CW'(rd_here);
      wtok  <= (wtok & ~xo[0]) | xi[0];
      rtok  <= (rtok & ~xo[1]) | xi[1];
    end
  end

  a_r4_write_token_arrives: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wtok) |-> $past(xi[0]));
  a_r5_read_token_arrives: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rtok) |-> $past(xi[1]));
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/cascade_fifo.sv
module cascade_fifo #(
  parameter int WIDTH  = 9,
  parameter int DEPTH  = 4,
  parameter int NSLICE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  din,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  dout,
  output logic              full,
  output logic              empty,
  output logic [NSLICE-1:0] half_full
);
  localparam int CW = $clog2(DEPTH+1);

  logic [1:0]       xo_a [NSLICE];
  logic [WIDTH-1:0] q_a  [NSLICE];
  logic [CW-1:0]    cnt_a [NSLICE];
  logic [NSLICE-1:0] full_v, empty_v, wtok_v, rtok_v;

  assign full  = |full_v;
  assign empty = |empty_v;
  wire wr_go = wr_en & ~full;
  wire rd_go = rd_en & ~empty;

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    localparam int PREV = (i + NSLICE - 1) % NSLICE;
    cascade_fifo_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .first_load_n(i != 0),
      .wr_go(wr_go), .rd_go(rd_go), .din(din),
      .xi(xo_a[PREV]), .xo(xo_a[i]), .q(q_a[i]),
      .empty_f(empty_v[i]), .full_f(full_v[i]), .half_f(half_full[i]),
      .wtok(wtok_v[i]), .rtok(rtok_v[i]), .count(cnt_a[i])
    );
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < NSLICE; i++) dout |= q_a[i];
  end

  int total;
  always_comb begin
    total = 0;
    for (int i = 0; i < NSLICE; i++) total += int'(cnt_a[i]);
  end

  a_r2_one_write_token: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(wtok_v));
  a_r2_one_read_token: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(rtok_v));
  a_r7_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_en |=> $stable(total));
  a_r7_empty_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !wr_en |=> $stable(total));
  a_r6_full_means_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> total == NSLICE*DEPTH);
endmodule

// File: tb/cascade_fifo_tb.sv
module cascade_fifo_tb;
  localparam int WIDTH = 9, DEPTH = 4, NSLICE = 3, CAP = DEPTH*NSLICE;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [WIDTH-1:0] din = '0, dout;
  logic full, empty;
  logic [NSLICE-1:0] half_full;

  int checks = 0, fails = 0, wcnt = 0, rcnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  cascade_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NSLICE(NSLICE)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .rd_en(rd_en),
    .dout(dout), .full(full), .empty(empty), .half_full(half_full));

  function automatic logic [WIDTH-1:0] word(int k);
    return WIDTH'((k * 37 + 5) ^ (k >> 2));
  endfunction

  function automatic logic [NSLICE-1:0] exp_half();
    logic [NSLICE-1:0] v = '0;
    for (int j = 0; j < NSLICE; j++) begin
      int c = 0;
      for (int k = rcnt; k < wcnt; k++) if (((k / DEPTH) % NSLICE) == j) c++;
      v[j] = (c > DEPTH/2);
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic compare();
    chk(empty == (wcnt == rcnt), "R6 empty flag", empty, wcnt == rcnt);
    chk(full == (wcnt - rcnt == CAP), "R6 full flag", full, wcnt - rcnt == CAP);
    if (wcnt != rcnt) chk(dout == word(rcnt), "R3 head word", dout, word(rcnt));
    chk(half_full == exp_half(), "R2/R4/R5/R8 half_full", half_full, exp_half());
  endtask

  task automatic step(input logic w, input logic r);
    logic aw, ar;
    aw = w && (wcnt - rcnt < CAP);
    ar = r && (wcnt != rcnt);
    wr_en = w; rd_en = r;
    din = aw ? word(wcnt) : word(wcnt + 1000);
    @(posedge clk);
    if (aw) wcnt++;
    if (ar) rcnt++;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    compare();
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(empty == 1 && full == 0 && half_full == '0, "R1 flags in reset",
        {empty, full, half_full}, 5'b10000);
    rst_n = 1;
    @(negedge clk);
    chk(empty == 1 && full == 0 && half_full == '0, "R1 flags after reset",
        {empty, full, half_full}, 5'b10000);
    // R7: read while empty is ignored
    step(0, 1);
    // R4: fill all slices
    for (int i = 0; i < CAP; i++) step(1, 0);
    // R7: write while full is ignored
    step(1, 0);
    chk(full == 1 && dout == word(0), "R7 write into full", dout, word(0));
    // R9: both strobes when full: only the read takes effect
    step(1, 1);
    chk(wcnt == CAP && rcnt == 1, "R9 full read+write", rcnt, 1);
    // R5: drain through the ring wrap
    for (int i = 0; i < CAP; i++) step(0, 1);
    step(1, 1);
    chk(wcnt - rcnt == 1, "R9 empty read+write", wcnt - rcnt, 1);
    // mixed-ratio sweeps, several token laps
    for (int ph = 0; ph < 8; ph++) begin
      for (int c = 0; c < 250; c++) begin
        logic w, r;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (ph % 4)
          0: begin w = lfsr[1:0] != 0; r = lfsr[3:2] == 0; end
          1: begin w = lfsr[1:0] == 0; r = lfsr[3:2] != 0; end
          2: begin w = lfsr[0];        r = lfsr[5];        end
          default: begin w = 1;        r = lfsr[2] | lfsr[7]; end
        endcase
        step(w, r);
      end
    end
    // R7: read while empty after draining
    while (wcnt != rcnt) step(0, 1);
    step(0, 1);
    chk(empty == 1 && rcnt == wcnt, "R7 read from empty", empty, 1);
    report();
  end
endmodule